// File: doc/BRIEF.md
# SD Host Interrupt Status Unit

This block collects the events of an SD/MMC host controller into two byte-wide sticky status registers. Each register has a byte-wide enable register beside it, and together they drive one level-sensitive interrupt line to the processor. The command and data engines deliver single-cycle event pulses. The block sets a sticky bit for each pulse and holds it until software writes a 1 to that bit. The status bytes also carry live level bits: write protect and the two card-detect inputs. These pass through a two-flop synchroniser before they appear.

A control byte holds four settings: the master interrupt enable, the card-detect polarity, and which card-detect sources count (a GPI pin, the DAT3 line, or both). From the selected sources the block derives a "card present" level. It raises a sticky change event on every edge of that level and an insertion event on every rising edge. The synchroniser and edge register reset to zero. A card that is present when reset ends is therefore reported as an insertion. Changing the polarity or source selection can also raise change or insertion events.

Software reaches the block through a byte-wide register port with a single address bus. A write takes effect on the clock edge where `reg_wr_en` is high. `reg_rd_data` is a registered copy of the register at `reg_addr`, and it updates one clock after the address is presented.

Top module: `sdh_irq_status`

## Requirements
- R1: After reset, every register reads 0x00 and `irq` is low.
- R2: A pulse on an event input sets its sticky bit one clock later, and the bit stays set until it is cleared. Status byte 1 is at address 1 and holds these bits: bit0 SDIO interrupt, bit1 command-response done, bit2 response timeout, bit3 auto-stop done, bit4 data timeout, bit5 response CRC error, bit6 read CRC error, bit7 write CRC error.
- R3: A write to a status address clears exactly the sticky bits written as 1 and leaves the others as they were. Writing 0xFF clears every sticky bit.
- R4: If an event pulse and a write-1-to-clear of the same bit land in the same cycle, the bit stays set.
- R5: `irq` is registered. It goes high one clock after any sticky bit is set whose enable bit is also set, provided the master enable (bit0 of the control byte at address 4) is 1. It stays high until the bit or its enable is cleared.
- R6: While the master enable is 0, `irq` stays low whatever the status and enable bits hold.
- R7: Status byte 0 (address 0) shows three live level bits: bit1 write protect, bit2 DAT3 card-detect level, bit3 GPI card-detect level. Each follows its input through a two-flop synchroniser. Writes to these bits have no effect.
- R8: Status byte 0 holds block done at bit5 and multi-block done at bit4 as sticky event bits. Enable byte 0 (address 2) gates them with its bits 5 and 4.
- R9: The control byte selects the card-present level. Bit1 is polarity: 1 means a high GPI level means present. Bit2 makes the GPI pin a source, and bit3 makes DAT3 a source, where a high DAT3 means present. "Present" is the OR of the selected sources. Any edge of "present" sets bit6 of status byte 0, and a rising edge sets bit7.
- R10: Some bits and addresses are unimplemented. They read 0 and never gate an interrupt: enable byte 0 bits 0..3, enable byte 1 (address 3) bit0, status byte 0 bit0, control bits 4..7, and addresses 5..7. An SDIO event alone therefore never raises `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 3 | Register address for reads and writes |
| reg_wr_en | input | 1 | Write strobe |
| reg_wr_data | input | 8 | Write data |
| reg_rd_data | output | 8 | Registered read data |
| ev_sdio | input | 1 | SDIO interrupt pulse |
| ev_cmd_done | input | 1 | Command-response done pulse |
| ev_rsp_tmo | input | 1 | Response timeout pulse |
| ev_autostop | input | 1 | Auto-stop done pulse |
| ev_data_tmo | input | 1 | Data timeout pulse |
| ev_rsp_crc | input | 1 | Response CRC error pulse |
| ev_rd_crc | input | 1 | Read data CRC error pulse |
| ev_wr_crc | input | 1 | Write data CRC error pulse |
| ev_mblk_done | input | 1 | Multi-block done pulse |
| ev_blk_done | input | 1 | Block done pulse |
| wp_in | input | 1 | Write-protect level, asynchronous |
| cd_gpi_in | input | 1 | GPI card-detect level, asynchronous |
| cd_dat3_in | input | 1 | DAT3 card-detect level, asynchronous |
| irq | output | 1 | Level interrupt to the processor |

## Verification
The assertions check on every cycle that the interrupt follows the enabled status and the master enable with one clock of latency. They also check that sticky bits in byte 1 never drop without a clearing write, that a clear loses against a coinciding event, and that the write-protect mirror lags its input by exactly two clocks. The bench scenarios are what show the register map itself: the bit position of every event and the read-back of unimplemented bits. The bench also sweeps every combination of card-detect polarity, source selection and input levels to check the change and insertion events, and it confirms that writes leave the live level bits untouched.

// File: rtl/sdh_irq_pkg.sv
package sdh_irq_pkg;
  // Register addresses
  localparam int A_STS0 = 0;
  localparam int A_STS1 = 1;
  localparam int A_EN0  = 2;
  localparam int A_EN1  = 3;
  localparam int A_CTRL = 4;

  // Control byte bit positions
  localparam int C_MASTER  = 0;
  localparam int C_POL_HI  = 1;
  localparam int C_SEL_GPI = 2;
  localparam int C_SEL_D3  = 3;

  // Status byte 0 bit positions
  localparam int S0_WP     = 1;
  localparam int S0_CD_D3  = 2;
  localparam int S0_CD_GPI = 3;
  localparam int S0_MBLK   = 4;
  localparam int S0_BLK    = 5;
  localparam int S0_CHG    = 6;
  localparam int S0_INS    = 7;

  // Implemented-bit masks
  localparam logic [7:0] STS0_STICKY_MASK = 8'hF0;
  localparam logic [7:0] STS1_STICKY_MASK = 8'hFF;
  localparam logic [7:0] EN0_MASK         = 8'hF0;
  localparam logic [7:0] EN1_MASK         = 8'hFE;
  localparam logic [7:0] CTRL_MASK        = 8'h0F;

  typedef struct packed {
    logic sel_d3;
    logic sel_gpi;
    logic pol_hi;
    logic master;
  } ctrl_t;
endpackage

// File: rtl/sdh_sync_bit.sv
module sdh_sync_bit #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= d;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= {sh[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = sh[STAGES-1];
endmodule

// File: rtl/sdh_sticky_byte.sv
module sdh_sticky_byte #(
  parameter int         W    = 8,
  parameter logic [W-1:0] IMPL = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_i,
  input  logic         clr_we,
  input  logic [W-1:0] clr_bits,
  output logic [W-1:0] q
);
  logic [W-1:0] st;

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (IMPL[i]) begin : g_impl
      always_ff @(posedge clk) begin
        if (rst)
          st[i] <= 1'b0;
        else if (set_i[i])
          st[i] <= 1'b1;                 // event wins over clear
        else if (clr_we && clr_bits[i])
          st[i] <= 1'b0;
      end
    end else begin : g_none
      assign st[i] = 1'b0;
    end
  end

  assign q = st;
endmodule

// File: rtl/sdh_card_detect.sv
module sdh_card_detect (
  input  logic clk,
  input  logic rst,
  input  logic gpi_s,
  input  logic dat3_s,
  input  logic pol_hi,
  input  logic sel_gpi,
  input  logic sel_d3,
  output logic chg_ev,
  output logic ins_ev
);
  logic gpi_present;
  logic present;
  logic present_q;

  assign gpi_present = pol_hi ? gpi_s : ~gpi_s;
  assign present     = (sel_gpi & gpi_present) | (sel_d3 & dat3_s);

  always_ff @(posedge clk) begin
    if (rst) present_q <= 1'b0;
    else     present_q <= present;
  end

  assign chg_ev = present ^ present_q;
  assign ins_ev = present & ~present_q;
endmodule

// File: rtl/sdh_irq_status.sv
module sdh_irq_status
  import sdh_irq_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr_en,
  input  logic [DATA_W-1:0] reg_wr_data,
  output logic [DATA_W-1:0] reg_rd_data,
  input  logic              ev_sdio,
  input  logic              ev_cmd_done,
  input  logic              ev_rsp_tmo,
  input  logic              ev_autostop,
  input  logic              ev_data_tmo,
  input  logic              ev_rsp_crc,
  input  logic              ev_rd_crc,
  input  logic              ev_wr_crc,
  input  logic              ev_mblk_done,
  input  logic              ev_blk_done,
  input  logic              wp_in,
  input  logic              cd_gpi_in,
  input  logic              cd_dat3_in,
  output logic              irq
);
  localparam int NLVL = 3;

  // Synchronised level inputs: 0 write protect, 1 DAT3, 2 GPI
  logic [NLVL-1:0] lvl_raw;
  logic [NLVL-1:0] lvl_s;
  assign lvl_raw = {cd_gpi_in, cd_dat3_in, wp_in};

  for (genvar k = 0; k < NLVL; k++) begin : g_sync
    sdh_sync_bit #(.STAGES(SYNC_STAGES)) u_sync (
      .clk (clk),
      .rst (rst),
      .d   (lvl_raw[k]),
      .q   (lvl_s[k])
    );
  end

  // Control and enable registers
  ctrl_t             ctrl_q;
  logic [DATA_W-1:0] en0_q;
  logic [DATA_W-1:0] en1_q;

  logic wr_sts0, wr_sts1, wr_en0, wr_en1, wr_ctrl;
  assign wr_sts0 = reg_wr_en && (reg_addr == ADDR_W'(A_STS0));
  assign wr_sts1 = reg_wr_en && (reg_addr == ADDR_W'(A_STS1));
  assign wr_en0  = reg_wr_en && (reg_addr == ADDR_W'(A_EN0));
  assign wr_en1  = reg_wr_en && (reg_addr == ADDR_W'(A_EN1));
  assign wr_ctrl = reg_wr_en && (reg_addr == ADDR_W'(A_CTRL));

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      en0_q  <= '0;
      en1_q  <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= ctrl_t'(reg_wr_data[3:0]);
      if (wr_en0)  en0_q  <= reg_wr_data & EN0_MASK;
      if (wr_en1)  en1_q  <= reg_wr_data & EN1_MASK;
    end
  end

  // Card detect edge events
  logic cd_chg, cd_ins;
  sdh_card_detect u_cd (
    .clk     (clk),
    .rst     (rst),
    .gpi_s   (lvl_s[2]),
    .dat3_s  (lvl_s[1]),
    .pol_hi  (ctrl_q.pol_hi),
    .sel_gpi (ctrl_q.sel_gpi),
    .sel_d3  (ctrl_q.sel_d3),
    .chg_ev  (cd_chg),
    .ins_ev  (cd_ins)
  );

  // Sticky status bytes
  logic [DATA_W-1:0] set0, set1;
  logic [DATA_W-1:0] sts0_q, sts1_q;

  always_comb begin
    set0         = '0;
    set0[S0_MBLK] = ev_mblk_done;
    set0[S0_BLK]  = ev_blk_done;
    set0[S0_CHG]  = cd_chg;
    set0[S0_INS]  = cd_ins;
  end

  assign set1 = {ev_wr_crc, ev_rd_crc, ev_rsp_crc, ev_data_tmo,
                 ev_autostop, ev_rsp_tmo, ev_cmd_done, ev_sdio};

  sdh_sticky_byte #(.W(DATA_W), .IMPL(STS0_STICKY_MASK)) u_sts0 (
    .clk      (clk),
    .rst      (rst),
    .set_i    (set0),
    .clr_we   (wr_sts0),
    .clr_bits (reg_wr_data),
    .q        (sts0_q)
  );

  sdh_sticky_byte #(.W(DATA_W), .IMPL(STS1_STICKY_MASK)) u_sts1 (
    .clk      (clk),
    .rst      (rst),
    .set_i    (set1),
    .clr_we   (wr_sts1),
    .clr_bits (reg_wr_data),
    .q        (sts1_q)
  );

  // Level bits merged into status byte 0
  logic [DATA_W-1:0] lvl_byte;
  always_comb begin
    lvl_byte            = '0;
    lvl_byte[S0_WP]     = lvl_s[0];
    lvl_byte[S0_CD_D3]  = lvl_s[1];
    lvl_byte[S0_CD_GPI] = lvl_s[2];
  end

  // Interrupt
  logic irq_next;
  assign irq_next = ctrl_q.master & (|((sts0_q & en0_q) | (sts1_q & en1_q)));

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= irq_next;
  end

  // Registered read port
  logic [DATA_W-1:0] rd_mux;
  always_comb begin
    unique case (reg_addr)
      ADDR_W'(A_STS0): rd_mux = sts0_q | lvl_byte;
      ADDR_W'(A_STS1): rd_mux = sts1_q;
      ADDR_W'(A_EN0):  rd_mux = en0_q;
      ADDR_W'(A_EN1):  rd_mux = en1_q;
      ADDR_W'(A_CTRL): rd_mux = DATA_W'({4'b0, ctrl_q});
      default:         rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rd_data <= '0;
    else     reg_rd_data <= rd_mux;
  end
endmodule

// File: rtl/sdh_irq_status_chk.sv
module sdh_irq_status_chk (
  input logic       clk,
  input logic       rst,
  input logic [2:0] reg_addr,
  input logic       reg_wr_en,
  input logic [7:0] reg_wr_data,
  input logic       ev_rsp_tmo,
  input logic       wp_in,
  input logic       irq,
  input logic [7:0] sts0_q,
  input logic [7:0] sts1_q,
  input logic [7:0] en0_q,
  input logic [7:0] en1_q,
  input logic       master,
  input logic       wp_s
);
  logic [1:0] since_rst;
  always_ff @(posedge clk) begin
    if (rst)                 since_rst <= '0;
    else if (since_rst != 3) since_rst <= since_rst + 2'd1;
  end

  logic wr1;
  assign wr1 = reg_wr_en && (reg_addr == 3'd1);

  // R5
  a_r5_irq_raise: assert property (@(posedge clk) disable iff (rst)
    (master && |((sts0_q & en0_q) | (sts1_q & en1_q))) |=> irq);

  // R6
  a_r6_master_gate: assert property (@(posedge clk) disable iff (rst)
    !master |=> !irq);

  // R2
  a_r2_sticky_hold: assert property (@(posedge clk) disable iff (rst)
    !wr1 |=> ((sts1_q & $past(sts1_q)) == $past(sts1_q)));

  // R4
  a_r4_set_wins: assert property (@(posedge clk) disable iff (rst)
    ev_rsp_tmo |=> sts1_q[2]);

  // R3
  a_r3_clear: assert property (@(posedge clk) disable iff (rst)
    (wr1 && reg_wr_data[2] && !ev_rsp_tmo) |=> !sts1_q[2]);

  // R7
  a_r7_wp_sync: assert property (@(posedge clk) disable iff (rst)
    (since_rst == 2'd3) |-> (wp_s == $past(wp_in, 2)));
endmodule

bind sdh_irq_status sdh_irq_status_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .reg_addr    (reg_addr),
  .reg_wr_en   (reg_wr_en),
  .reg_wr_data (reg_wr_data),
  .ev_rsp_tmo  (ev_rsp_tmo),
  .wp_in       (wp_in),
  .irq         (irq),
  .sts0_q      (sts0_q),
  .sts1_q      (sts1_q),
  .en0_q       (en0_q),
  .en1_q       (en1_q),
  .master      (ctrl_q.master),
  .wp_s        (lvl_s[0])
);

// File: tb/sdh_irq_status_tb_top.sv
module sdh_irq_status_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] reg_addr = '0;
  logic       reg_wr_en = 1'b0;
  logic [7:0] reg_wr_data = '0;
  logic [7:0] reg_rd_data;
  logic [9:0] ev = '0;   // 0..7 status byte 1 bits, 8 multi-block, 9 block
  logic       wp_in = 1'b0, cd_gpi_in = 1'b0, cd_dat3_in = 1'b0;
  logic       irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;   // 125 MHz

  sdh_irq_status dut_i (
    .clk (clk), .rst (rst),
    .reg_addr (reg_addr), .reg_wr_en (reg_wr_en),
    .reg_wr_data (reg_wr_data), .reg_rd_data (reg_rd_data),
    .ev_sdio (ev[0]), .ev_cmd_done (ev[1]), .ev_rsp_tmo (ev[2]),
    .ev_autostop (ev[3]), .ev_data_tmo (ev[4]), .ev_rsp_crc (ev[5]),
    .ev_rd_crc (ev[6]), .ev_wr_crc (ev[7]),
    .ev_mblk_done (ev[8]), .ev_blk_done (ev[9]),
    .wp_in (wp_in), .cd_gpi_in (cd_gpi_in), .cd_dat3_in (cd_dat3_in),
    .irq (irq)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = 3'(a); reg_wr_data = d; reg_wr_en = 1'b1;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = 3'(a);
    @(negedge clk);
    d = reg_rd_data;
  endtask

  task automatic pulse(input logic [9:0] v);
    @(negedge clk);
    ev = v;
    @(negedge clk);
    ev = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog all-requirements actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : stim
    logic [7:0] d;
    idle(4);
    @(negedge clk) rst = 1'b0;
    idle(2);

    // R1 reset state
    for (int a = 0; a < 5; a++) begin
      rd(a, d);
      chk("R1 reset reg", d, 8'h00);
    end
    chk("R1 reset irq", {7'b0, irq}, 8'h00);

    // R10 unimplemented bits and addresses
    wr(2, 8'hFF); rd(2, d); chk("R10 en0 readback", d, 8'hF0);
    wr(3, 8'hFF); rd(3, d); chk("R10 en1 readback", d, 8'hFE);
    wr(4, 8'hFF); rd(4, d); chk("R10 ctrl readback", d, 8'h0F);
    for (int a = 5; a < 8; a++) begin
      wr(a, 8'hFF); rd(a, d); chk("R10 unused addr", d, 8'h00);
    end
    wr(4, 8'h01); wr(2, 8'h00); wr(3, 8'h00);
    idle(6); wr(0, 8'hFF); wr(1, 8'hFF); idle(2);

    // R2/R5/R6/R3 sweep over every status byte 1 bit
    for (int b = 0; b < 8; b++) begin
      wr(1, 8'hFF);
      wr(3, 8'(1 << b));
      wr(4, 8'h01);
      pulse(10'(1 << b));
      idle(1);
      rd(1, d); chk("R2 event bit position", d, 8'(1 << b));
      idle(3); rd(1, d); chk("R2 sticky hold", d, 8'(1 << b));
      chk((b == 0) ? "R10 sdio not gated" : "R5 irq raised",
          {7'b0, irq}, (b == 0) ? 8'h00 : 8'h01);
      wr(4, 8'h00); idle(2);
      chk("R6 master off", {7'b0, irq}, 8'h00);
      wr(4, 8'h01); idle(2);
      wr(1, 8'(1 << b)); idle(2);
      rd(1, d); chk("R3 clear single", d, 8'h00);
      chk("R5 irq dropped", {7'b0, irq}, 8'h00);
    end

    // R3 partial clear leaves other bits
    pulse(10'h00E); wr(1, 8'h04); rd(1, d);
    chk("R3 partial clear", d, 8'h0A);
    wr(1, 8'hFF); rd(1, d); chk("R3 clear all", d, 8'h00);

    // R4 event and clear in the same cycle
    pulse(10'h002);
    @(negedge clk);
    reg_addr = 3'd1; reg_wr_data = 8'h06; reg_wr_en = 1'b1; ev = 10'h004;
    @(negedge clk);
    reg_wr_en = 1'b0; ev = '0;
    rd(1, d); chk("R4 set wins", d, 8'h04);
    wr(1, 8'hFF);

    // R8 block / multi-block done, gated by enable byte 0
    wr(3, 8'h00);
    pulse(10'h100); rd(0, d); chk("R8 mblk bit4", d & 8'hF0, 8'h10);
    idle(3); chk("R8 mblk no irq when disabled", {7'b0, irq}, 8'h00);
    wr(2, 8'h10); idle(2); chk("R8 mblk irq", {7'b0, irq}, 8'h01);
    wr(0, 8'h10); wr(2, 8'h20);
    pulse(10'h200); rd(0, d); chk("R8 blk bit5", d & 8'hF0, 8'h20);
    idle(2); chk("R8 blk irq", {7'b0, irq}, 8'h01);
    wr(0, 8'hFF); wr(2, 8'h00); idle(2);

    // R7 level mirrors, unaffected by writes
    for (int p = 0; p < 8; p++) begin
      @(negedge clk);
      wp_in = p[0]; cd_dat3_in = p[1]; cd_gpi_in = p[2];
      idle(1);
      rd(0, d); chk("R7 mirror lag", d & 8'h0E, 8'h00 | (8'(p) << 1) & 8'h0E);
      idle(3);
      wr(0, 8'hFF);
      rd(0, d); chk("R7 mirror after write", d & 8'h0E, 8'(p) << 1);
    end

    // R9 card detect: polarity x sources x new levels
    for (int c = 0; c < 8; c++) begin
      for (int lv = 0; lv < 4; lv++) begin
        logic pol, sg, sd, g, d3, p_old, p_new;
        pol = c[0]; sg = c[1]; sd = c[2]; g = lv[0]; d3 = lv[1];
        p_old = (sg & ~pol);
        p_new = (sg & (pol ? g : ~g)) | (sd & d3);
        @(negedge clk); cd_gpi_in = 1'b0; cd_dat3_in = 1'b0;
        wr(4, {4'b0, sd, sg, pol, 1'b0});
        idle(6);
        wr(0, 8'hFF);
        @(negedge clk); cd_gpi_in = g; cd_dat3_in = d3;
        idle(6);
        rd(0, d);
        chk("R9 change/insert", d & 8'hC0, {p_new & ~p_old, p_new ^ p_old, 6'b0});
      end
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule